// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder with Compressed Test Mode

This block is a synthesizable device-side model of a small asynchronous DRAM. It watches the row strobe, column strobe and write-enable pins and sorts every row-strobe cycle into one of five kinds:

- a read;
- an early write;
- a refresh with only the row strobe;
- a refresh with the column strobe asserted before the row strobe (CAS-before-RAS);
- an entry into a compressed parallel-test mode.

The strobes are asynchronous. A fast internal clock samples them, and edge detection on the sampled copies drives all decisions. A reduced array of register cells stores the data.

An internal refresh row counter counts the CAS-before-RAS refreshes. The test mode stays latched across later cycles until a refresh cycle of either kind clears it. While the mode is active:

- column address bits 10 and 9 are ignored;
- each data pin covers four cells, so a write stores sixteen bits at once;
- a read drives each pin high when its four cells agree and low when they differ.

Read data follows extended-data-out behaviour. It stays driven after the column strobe rises, until the next column-strobe fall or until both strobes are high. The data pins are modelled as a separate input bus, output bus and output enable. The cycle kind, the test flag and the refresh row are brought out so that the surrounding logic can observe them.

Top module: `dram_strobe_decoder`

## Requirements
- R1: A row-strobe fall while the column strobe is low and write-enable is high is a CAS-before-RAS refresh. It sets `cycle_kind` to 4 and advances `refresh_row` by one.
- R2: `refresh_row` is REF_W bits wide and wraps from its all-ones value to 0 on the next CAS-before-RAS refresh.
- R3: A row-strobe fall while both the column strobe and write-enable are low sets `cycle_kind` to 5 and raises `test_active`. This does not change `refresh_row`. `test_active` stays high across later reads and writes.
- R4: A row-strobe cycle with no column-strobe fall before the row strobe rises sets `cycle_kind` to 3. This cycle, or a CAS-before-RAS refresh with write-enable high, clears `test_active`.
- R5: If write-enable is low at a column-strobe fall inside a row cycle, the access is an early write. `dq_in` is stored at the cell selected by the row and by column bits {10,9,1:0}, `cycle_kind` becomes 2, and `dq_oe` is low.
- R6: If write-enable is high at a column-strobe fall inside a row cycle, the access is a read. `cycle_kind` becomes 1, and `dq_oe` goes high with the stored nibble on `dq_out`. The output stays driven after the column strobe rises. It turns off at the next column-strobe fall that is a write, or once both strobes are high.
- R7: In test mode, a write stores `dq_in` into the four cells that share the row and column bits 1:0 and differ only in column bits 10:9.
- R8: In test mode, a read ignores column bits 10:9. Bit b of `dq_out` is 1 when bit b of the four cells is equal, and 0 otherwise.
- R9: After reset, `cycle_kind` is 0, `test_active` is 0, `refresh_row` is 0, `dq_oe` is 0 and every cell holds 0.
- R10: In a hidden refresh, the column strobe stays low while the row strobe rises and falls again. The read output stays driven through this, and the new row-strobe fall counts as a CAS-before-RAS refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data pins |
| dq_out | output | DQ_W | Read data pins |
| dq_oe | output | 1 | Read data output enable |
| cycle_kind | output | 3 | Last classified cycle: 0 none, 1 read, 2 write, 3 row-only refresh, 4 CAS-before-RAS refresh, 5 test entry |
| test_active | output | 1 | Compressed test mode latched |
| refresh_row | output | REF_W | Internal refresh row counter |

## Verification
The bench uses the default parameters. These are an 11-bit address with test bits at 10:9, four data pins, four rows, two low column bits, and an 11-bit refresh counter. With these values every one of the four cells in a compressed group can be written and read back individually in normal mode. This makes both the agreeing and the disagreeing per-pin results of a test-mode read reachable. The full 2048-step wrap of the refresh counter also fits within the run length.

// File: rtl/dram_dec_pkg.sv
// Package: shared cycle-kind encoding for the DRAM strobe decoder.
// Assumes: the encoding is visible at the top-level cycle_kind port.
package dram_dec_pkg;
    typedef enum logic [2:0] {
        CYC_NONE       = 3'd0,
        CYC_READ       = 3'd1,
        CYC_WRITE      = 3'd2,
        CYC_RAS_ONLY   = 3'd3,
        CYC_CBR        = 3'd4,
        CYC_TEST_ENTRY = 3'd5
    } cyc_kind_e;
endpackage

// File: rtl/strobe_sampler.sv
// Module: strobe_sampler
// Registers the asynchronous strobes, address and data once, keeps the
// previous strobe levels, and flags row/column strobe edges.
// Assumes: the strobes are stable for at least two clk periods per phase.
module strobe_sampler #(
    parameter int ADDR_W = 11,
    parameter int DQ_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic              ras_lvl,
    output logic              cas_lvl,
    output logic              we_lvl,
    output logic [ADDR_W-1:0] addr_s,
    output logic [DQ_W-1:0]   dq_s,
    output logic              ras_fall,
    output logic              ras_rise,
    output logic              cas_fall
);
    logic ras_prev, cas_prev;

    // Sample stage: capture pins on the fast clock, strobes idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_lvl <= 1'b1;
            cas_lvl <= 1'b1;
            we_lvl  <= 1'b1;
            addr_s  <= '0;
            dq_s    <= '0;
        end else begin
            ras_lvl <= ras_n;
            cas_lvl <= cas_n;
            we_lvl  <= we_n;
            addr_s  <= addr;
            dq_s    <= dq_in;
        end
    end

    // History stage: previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_prev <= 1'b1;
            cas_prev <= 1'b1;
        end else begin
            ras_prev <= ras_lvl;
            cas_prev <= cas_lvl;
        end
    end

    // Edge flags derived from the two stages.
    always_comb begin
        ras_fall = ras_prev & ~ras_lvl;
        ras_rise = ~ras_prev & ras_lvl;
        cas_fall = cas_prev & ~cas_lvl;
    end
endmodule

// File: rtl/cycle_classifier.sv
// Module: cycle_classifier
// Decodes strobe ordering into cycle kinds, latches the row address,
// keeps the compressed test-mode flag and the refresh row counter.
// Assumes: edge flags are single-cycle pulses from strobe_sampler.
module cycle_classifier
    import dram_dec_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int REF_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_fall,
    input  logic              ras_rise,
    input  logic              cas_fall,
    input  logic              cas_lvl,
    input  logic              we_lvl,
    input  logic [ADDR_W-1:0] addr_s,
    output logic [ADDR_W-1:0] row_addr,
    output cyc_kind_e         kind,
    output logic              test_mode,
    output logic [REF_W-1:0]  ref_cnt,
    output logic              issue_rd,
    output logic              issue_wr
);
    logic row_active;
    logic cas_seen;
    logic cbr_start;

    // Access strobes: a column fall inside an open row starts an access.
    always_comb begin
        issue_rd  = cas_fall & row_active & we_lvl;
        issue_wr  = cas_fall & row_active & ~we_lvl;
        cbr_start = ras_fall & ~cas_lvl;
    end

    // Row cycle tracking: open/close rows and remember column activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_active <= 1'b0;
            cas_seen   <= 1'b0;
            row_addr   <= '0;
        end else if (ras_fall && cas_lvl) begin
            row_active <= 1'b1;
            cas_seen   <= 1'b0;
            row_addr   <= addr_s;
        end else if (ras_rise) begin
            row_active <= 1'b0;
        end else if (cas_fall && row_active) begin
            cas_seen <= 1'b1;
        end
    end

    // Cycle kind: record the most recent classification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind <= CYC_NONE;
        end else if (cbr_start) begin
            kind <= we_lvl ? CYC_CBR : CYC_TEST_ENTRY;
        end else if (issue_rd) begin
            kind <= CYC_READ;
        end else if (issue_wr) begin
            kind <= CYC_WRITE;
        end else if (ras_rise && row_active && !cas_seen) begin
            kind <= CYC_RAS_ONLY;
        end
    end

    // Test mode latch: set by refresh-with-write, cleared by any refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_mode <= 1'b0;
        end else if (cbr_start) begin
            test_mode <= ~we_lvl;
        end else if (ras_rise && row_active && !cas_seen) begin
            test_mode <= 1'b0;
        end
    end

    // Refresh counter: steps once per CAS-before-RAS refresh, wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt <= '0;
        end else if (cbr_start && we_lvl) begin
            ref_cnt <= ref_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cell_array.sv
// Module: cell_array
// Reduced register-cell store. Normal accesses address one nibble by row
// and column bits {top two, low COL_LO_W}; test mode writes four nibbles
// at once and compresses four reads into a per-pin equality result.
// Assumes: the top two address bits are the test-ignored column bits.
module cell_array #(
    parameter int ADDR_W   = 11,
    parameter int DQ_W     = 4,
    parameter int ROW_W    = 2,
    parameter int COL_LO_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] row_addr,
    input  logic [ADDR_W-1:0] col_addr,
    input  logic [DQ_W-1:0]   wdata,
    output logic [DQ_W-1:0]   rdata
);
    localparam int GROUPS = 4;
    localparam int HI_LSB = ADDR_W - 2;
    localparam int IDX_W  = ROW_W + 2 + COL_LO_W;
    localparam int CELLS  = 1 << IDX_W;

    logic [DQ_W-1:0]     mem [CELLS];
    logic [ROW_W-1:0]    row_sel;
    logic [1:0]          hi_sel;
    logic [COL_LO_W-1:0] lo_sel;
    logic [DQ_W-1:0]     grp_data [GROUPS];
    logic [DQ_W-1:0]     cmp_data;

    // Address split into row, test-ignored bits and low column bits.
    always_comb begin
        row_sel = row_addr[ROW_W-1:0];
        hi_sel  = col_addr[HI_LSB +: 2];
        lo_sel  = col_addr[COL_LO_W-1:0];
    end

    // Storage: single-cell write normally, four-cell write in test mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CELLS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            if (test_mode) begin
                for (int g = 0; g < GROUPS; g++)
                    mem[{row_sel, 2'(g), lo_sel}] <= wdata;
            end else begin
                mem[{row_sel, hi_sel, lo_sel}] <= wdata;
            end
        end
    end

    // Group reads: the four cells a pin covers in test mode.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_data[g] = mem[{row_sel, 2'(g), lo_sel}];
    end

    // Per-pin compression: high when the four cells agree.
    for (genvar b = 0; b < DQ_W; b++) begin : g_cmp
        assign cmp_data[b] = (grp_data[0][b] == grp_data[1][b]) &&
                             (grp_data[0][b] == grp_data[2][b]) &&
                             (grp_data[0][b] == grp_data[3][b]);
    end

    // Read result selection by mode.
    always_comb begin
        rdata = test_mode ? cmp_data : mem[{row_sel, hi_sel, lo_sel}];
    end
endmodule

// File: rtl/data_output.sv
// Module: data_output
// Extended-data-out driver: latches read data at the column fall and
// keeps it driven until a write access or both strobes idle high.
// Assumes: issue_rd/issue_wr are single-cycle pulses.
module data_output #(
    parameter int DQ_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_rd,
    input  logic            issue_wr,
    input  logic [DQ_W-1:0] rdata,
    input  logic            ras_lvl,
    input  logic            cas_lvl,
    output logic [DQ_W-1:0] dq_out,
    output logic            dq_oe
);
    // Output latch and enable control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
        end else if (issue_rd) begin
            dq_out <= rdata;
            dq_oe  <= 1'b1;
        end else if (issue_wr || (ras_lvl && cas_lvl)) begin
            dq_oe <= 1'b0;
        end
    end
endmodule

// File: rtl/dram_strobe_decoder.sv
// Module: dram_strobe_decoder (top)
// Small DRAM model: samples asynchronous strobes, classifies cycles,
// stores data in a reduced cell array, runs the compressed test mode.
// Assumes: clk is several times faster than any strobe phase.
module dram_strobe_decoder
    import dram_dec_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int DQ_W     = 4,
    parameter int ROW_W    = 2,
    parameter int COL_LO_W = 2,
    parameter int REF_W    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic [2:0]        cycle_kind,
    output logic              test_active,
    output logic [REF_W-1:0]  refresh_row
);
    logic              ras_lvl, cas_lvl, we_lvl;
    logic [ADDR_W-1:0] addr_s, row_addr;
    logic [DQ_W-1:0]   dq_s, rdata;
    logic              ras_fall, ras_rise, cas_fall;
    logic              issue_rd, issue_wr;
    cyc_kind_e         kind;

    strobe_sampler #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .ras_lvl(ras_lvl), .cas_lvl(cas_lvl),
        .we_lvl(we_lvl), .addr_s(addr_s), .dq_s(dq_s), .ras_fall(ras_fall),
        .ras_rise(ras_rise), .cas_fall(cas_fall)
    );

    cycle_classifier #(.ADDR_W(ADDR_W), .REF_W(REF_W)) u_cls (
        .clk(clk), .rst_n(rst_n), .ras_fall(ras_fall), .ras_rise(ras_rise),
        .cas_fall(cas_fall), .cas_lvl(cas_lvl), .we_lvl(we_lvl),
        .addr_s(addr_s), .row_addr(row_addr), .kind(kind),
        .test_mode(test_active), .ref_cnt(refresh_row),
        .issue_rd(issue_rd), .issue_wr(issue_wr)
    );

    cell_array #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .ROW_W(ROW_W),
                 .COL_LO_W(COL_LO_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .test_mode(test_active), .wr_en(issue_wr),
        .row_addr(row_addr), .col_addr(addr_s), .wdata(dq_s), .rdata(rdata)
    );

    data_output #(.DQ_W(DQ_W)) u_out (
        .clk(clk), .rst_n(rst_n), .issue_rd(issue_rd), .issue_wr(issue_wr),
        .rdata(rdata), .ras_lvl(ras_lvl), .cas_lvl(cas_lvl),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // Port view of the cycle kind.
    assign cycle_kind = 3'(kind);
endmodule

// File: rtl/dram_dec_checker.sv
// Module: dram_dec_checker
// Temporal checks on the decoder's ports, bound to the top module.
// Assumes: reset is asserted from time zero.
module dram_dec_checker #(
    parameter int REF_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cycle_kind,
    input logic             test_active,
    input logic [REF_W-1:0] refresh_row,
    input logic             dq_oe
);
    // R1, R2: counter moves only by +1 (with wrap) on a refresh cycle.
    assert_refresh_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(refresh_row) |->
            (refresh_row == REF_W'($past(refresh_row) + 1'b1)) && (cycle_kind == 3'd4));

    // R3: test mode only turns on with a test-entry cycle.
    assert_test_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_active) |-> cycle_kind == 3'd5);

    // R4: test mode only turns off with a refresh cycle.
    assert_test_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_active) |-> (cycle_kind == 3'd3 || cycle_kind == 3'd4));

    // R5: write accesses never drive the outputs.
    assert_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_kind == 3'd2 |-> !dq_oe);

    // R6: the output driver starts only with a read.
    assert_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> cycle_kind == 3'd1);
endmodule

bind dram_strobe_decoder dram_dec_checker #(.REF_W(REF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cycle_kind(cycle_kind),
    .test_active(test_active), .refresh_row(refresh_row), .dq_oe(dq_oe)
);

// File: tb/tb_dram_strobe_decoder.sv
module tb_dram_strobe_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;
    localparam int LIMIT      = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [10:0] addr = '0;
    logic [3:0]  dq_in = '0;
    logic [3:0]  dq_out;
    logic        dq_oe;
    logic [2:0]  cycle_kind;
    logic        test_active;
    logic [10:0] refresh_row;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    dram_strobe_decoder dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .cycle_kind(cycle_kind), .test_active(test_active),
        .refresh_row(refresh_row)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: act %0d cycles exp <= %0d", cycles, LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (HOLD) @(negedge clk);
    endtask

    // Early write: row, then column with WE low at the column fall.
    task automatic do_write(input logic [10:0] row, input logic [10:0] col,
                            input logic [3:0] d);
        addr = row; hold();
        ras_n = 1'b0; hold();
        addr = col; we_n = 1'b0; dq_in = d; hold();
        cas_n = 1'b0; hold();
        chk("R5 write kind", cycle_kind, 2);
        chk("R5 write no drive", dq_oe, 0);
        cas_n = 1'b1; we_n = 1'b1; hold();
        ras_n = 1'b1; hold();
    endtask

    // Read with extended-data-out checks.
    task automatic do_read(input logic [10:0] row, input logic [10:0] col,
                           input logic [3:0] exp, input string req);
        addr = row; hold();
        ras_n = 1'b0; hold();
        addr = col; hold();
        cas_n = 1'b0; hold();
        chk({req, " read kind"}, cycle_kind, 1);
        chk({req, " read oe"}, dq_oe, 1);
        chk({req, " read data"}, dq_out, exp);
        cas_n = 1'b1; hold();
        chk("R6 edo still driven", dq_oe, 1);
        chk("R6 edo data held", dq_out, exp);
        ras_n = 1'b1; hold();
        chk("R6 off when idle", dq_oe, 0);
    endtask

    task automatic do_ras_only(input logic [10:0] row);
        addr = row; hold();
        ras_n = 1'b0; hold();
        ras_n = 1'b1; hold();
        chk("R4 ras-only kind", cycle_kind, 3);
        chk("R4 ras-only clears test", test_active, 0);
    endtask

    task automatic do_cbr(input logic we);
        cas_n = 1'b0; we_n = we; hold();
        ras_n = 1'b0; hold();
        ras_n = 1'b1; hold();
        cas_n = 1'b1; we_n = 1'b1; hold();
    endtask

    // Page mode: read then write in one row; write turns output off.
    task automatic page_read_write();
        addr = 11'd1; hold();
        ras_n = 1'b0; hold();
        addr = 11'h001; hold();
        cas_n = 1'b0; hold();
        chk("R6 page read data", dq_out, 4'hA);
        cas_n = 1'b1; hold();
        addr = 11'h002; we_n = 1'b0; dq_in = 4'h3; hold();
        cas_n = 1'b0; hold();
        chk("R6 next cas write oe", dq_oe, 0);
        chk("R5 page write kind", cycle_kind, 2);
        cas_n = 1'b1; we_n = 1'b1; hold();
        ras_n = 1'b1; hold();
    endtask

    // Hidden refresh: CAS held low across a second RAS pulse.
    task automatic hidden_refresh();
        addr = 11'd1; hold();
        ras_n = 1'b0; hold();
        addr = 11'h001; hold();
        cas_n = 1'b0; hold();
        ras_n = 1'b1; hold();
        chk("R10 driven between pulses", dq_oe, 1);
        ras_n = 1'b0; hold();
        chk("R10 hidden kind cbr", cycle_kind, 4);
        chk("R10 refresh step", refresh_row, 3);
        chk("R10 still driven", dq_oe, 1);
        chk("R10 data held", dq_out, 4'hA);
        ras_n = 1'b1; hold();
        cas_n = 1'b1; hold();
        chk("R10 off at idle", dq_oe, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 kind", cycle_kind, 0);
        chk("R9 test", test_active, 0);
        chk("R9 refresh", refresh_row, 0);
        chk("R9 oe", dq_oe, 0);
        do_read(11'd3, 11'h002, 4'h0, "R9 cleared cell");

        do_write(11'd1, 11'h001, 4'hA);
        do_read(11'd1, 11'h001, 4'hA, "R6");
        do_write(11'd1, 11'h201, 4'h5);
        do_read(11'd1, 11'h201, 4'h5, "R5 distinct cell");
        do_read(11'd1, 11'h001, 4'hA, "R5 untouched");

        do_ras_only(11'd2);
        do_cbr(1'b1);
        chk("R1 cbr kind", cycle_kind, 4);
        chk("R1 refresh step", refresh_row, 1);

        do_cbr(1'b0);
        chk("R3 entry kind", cycle_kind, 5);
        chk("R3 test on", test_active, 1);
        chk("R3 refresh unchanged", refresh_row, 1);

        do_write(11'd2, 11'h003, 4'b1010);
        chk("R3 latched after write", test_active, 1);
        do_read(11'd2, 11'h603, 4'hF, "R8 equal");
        chk("R3 latched after read", test_active, 1);
        do_ras_only(11'd0);
        do_read(11'd2, 11'h003, 4'b1010, "R7 group 0");
        do_read(11'd2, 11'h203, 4'b1010, "R7 group 1");
        do_read(11'd2, 11'h403, 4'b1010, "R7 group 2");
        do_read(11'd2, 11'h603, 4'b1010, "R7 group 3");

        do_write(11'd2, 11'h203, 4'b0110);
        do_cbr(1'b0);
        do_read(11'd2, 11'h003, 4'b0011, "R8 mixed");
        do_cbr(1'b1);
        chk("R4 cbr clears test", test_active, 0);
        chk("R1 exit refresh step", refresh_row, 2);

        hidden_refresh();
        page_read_write();
        do_read(11'd1, 11'h002, 4'h3, "R5 page stored");

        for (int i = 0; i < 2044; i++) do_cbr(1'b1);
        chk("R2 top value", refresh_row, 2047);
        do_cbr(1'b1);
        chk("R2 wrap", refresh_row, 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule